// File: doc/BRIEF.md
# Software Interrupt Fan-out Unit

This block turns one 32-bit control word, written by any core of a small multi-core cluster, into software-interrupt pending flags for a set of cores. The word carries a four-bit interrupt number, an eight-bit core mask and a two-bit filter mode. The filter mode either takes the mask as it is, or ignores the mask and aims at the writing core only, or at every core but the writer. A write with the reserved filter mode is discarded.

Each core keeps its own pending copy of all sixteen software interrupt numbers. When the same interrupt is sent to several cores, each one acknowledges and clears its own copy without affecting the others. A core acknowledges by presenting an interrupt number with a valid strobe. The bit clears on the same clock edge. If a new request reaches the same bit on that edge, the request takes priority so that it is not lost.

Top module: `sgi_dispatch`

## Requirements
- R1: Synchronous active-high reset clears every pending bit; after reset `pend` is all zeros.
- R2: With filter mode 0 (word bits 25:24 = 2'b00), every core c whose mask bit, word bit 16+c, is set gets pending bit `pend[c*16+id]` set on the clock edge that accepts the write.
- R3: With filter mode 1 (bits 25:24 = 2'b01), every core except the one named on `wr_core` gets its bit for the ID set, whatever the mask holds.
- R4: With filter mode 2 (bits 25:24 = 2'b10), only the core named on `wr_core` gets its bit for the ID set, whatever the mask holds.
- R5: A write with filter mode 3 (bits 25:24 = 2'b11) changes no pending bit.
- R6: Mask bits 16+c with c at or above NUM_CORES have no effect, so a list-mode write whose mask names only absent cores leaves `pend` unchanged.
- R7: The interrupt ID is word bits 3:0. Word bits 15:4 and 31:26 have no effect.
- R8: A core's acknowledge (`ack_valid[c]` high, ID on `ack_id[c*4+:4]`) clears only `pend[c*16+id]`, on the edge that samples it. Other cores' copies of that ID are kept.
- R9: When a write sets and an acknowledge clears the same bit on the same edge, the bit ends up set.
- R10: A pending bit stays set until that core acknowledges it, and it becomes set only through a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Control word write strobe |
| wr_core | input | CORE_W | ID of the core performing the write |
| wr_data | input | 32 | Control word: ID in 3:0, core mask in 23:16, filter mode in 25:24 |
| ack_valid | input | NUM_CORES | Per-core acknowledge strobe |
| ack_id | input | 4*NUM_CORES | Per-core acknowledged ID, core c at bits c*4+3:c*4 |
| pend | output | 16*NUM_CORES | Pending flags, core c ID i at bit c*16+i |

## Verification
Both a write and an acknowledge take effect on the rising edge that samples them. Their result appears on `pend` directly after that edge, one register and no further stage. The bench applies stimulus at the falling edge. Its reference model applies the same update on the next rising edge, and the full `pend` vector is compared at the following falling edge, half a cycle after the result is due. The same-edge collision between a set and a clear is therefore observed in the cycle it occurs, and so is the retention across idle cycles.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int SGI_IDS   = 16;
    localparam int SGI_IDW   = 4;
    localparam int MAX_CORES = 8;
    localparam int WORD_W    = 32;

    // field positions within the control word
    localparam int ID_LSB    = 0;
    localparam int MASK_LSB  = 16;
    localparam int MODE_LSB  = 24;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

    typedef struct packed {
        logic                   valid;
        sgi_filter_e            filter;
        logic [MAX_CORES-1:0]   core_mask;
        logic [SGI_IDW-1:0]     sgi_id;
    } sgi_req_t;

    function automatic sgi_req_t unpack_word(input logic wv, input logic [WORD_W-1:0] w);
        sgi_req_t r;
        r.valid     = wv;
        r.filter    = sgi_filter_e'(w[MODE_LSB +: 2]);
        r.core_mask = w[MASK_LSB +: MAX_CORES];
        r.sgi_id    = w[ID_LSB +: SGI_IDW];
        return r;
    endfunction

    function automatic logic [SGI_IDS-1:0] id_onehot(input logic [SGI_IDW-1:0] id);
        logic [SGI_IDS-1:0] v;
        v = '0;
        v[id] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sgi_word_decode.sv
module sgi_word_decode
    import sgi_pkg::*;
(
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output sgi_req_t          req
);

    always_comb begin
        req = unpack_word(wr_valid, wr_data);
        // the reserved mode never produces a request
        if (req.filter == FLT_RSVD) begin
            req.valid = 1'b0;
        end
    end

endmodule

// File: rtl/sgi_target_resolve.sv
module sgi_target_resolve
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
)(
    input  sgi_req_t           req,
    input  logic [CORE_W-1:0]  wr_core,
    output logic [NUM_CORES-1:0] targets,
    output logic [SGI_IDS-1:0]   set_vec
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic is_writer;
        assign is_writer = (wr_core == CORE_W'(c));
        always_comb begin
            unique case (req.filter)
                FLT_LIST:   targets[c] = req.valid & req.core_mask[c];
                FLT_OTHERS: targets[c] = req.valid & ~is_writer;
                FLT_SELF:   targets[c] = req.valid & is_writer;
                default:    targets[c] = 1'b0;
            endcase
        end
    end

    assign set_vec = id_onehot(req.sgi_id);

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
    import sgi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [SGI_IDS-1:0] set_vec,
    input  logic               ack_en,
    input  logic [SGI_IDW-1:0] ack_num,
    output logic [SGI_IDS-1:0] pend_q
);

    logic [SGI_IDS-1:0] clr_vec;
    logic [SGI_IDS-1:0] pend_d;

    always_comb begin
        clr_vec = ack_en ? id_onehot(ack_num) : '0;
        // set is applied after clear so a colliding request survives
        pend_d  = (pend_q & ~clr_vec) | (set_en ? set_vec : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_valid,
    input  logic [CORE_W-1:0]             wr_core,
    input  logic [31:0]                   wr_data,
    input  logic [NUM_CORES-1:0]          ack_valid,
    input  logic [4*NUM_CORES-1:0]        ack_id,
    output logic [16*NUM_CORES-1:0]       pend
);

    initial begin
        if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin
            $error("NUM_CORES out of range");
        end
    end

    sgi_req_t               req;
    logic [NUM_CORES-1:0]   targets;
    logic [SGI_IDS-1:0]     set_vec;

    sgi_word_decode u_dec (
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .req      (req)
    );

    sgi_target_resolve #(
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W)
    ) u_tgt (
        .req     (req),
        .wr_core (wr_core),
        .targets (targets),
        .set_vec (set_vec)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
        sgi_pend_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_en  (targets[c]),
            .set_vec (set_vec),
            .ack_en  (ack_valid[c]),
            .ack_num (ack_id[c*SGI_IDW +: SGI_IDW]),
            .pend_q  (pend[c*SGI_IDS +: SGI_IDS])
        );
    end

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NUM_CORES = 4,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_valid,
    input logic [CORE_W-1:0]       wr_core,
    input logic [31:0]             wr_data,
    input logic [NUM_CORES-1:0]    ack_valid,
    input logic [4*NUM_CORES-1:0]  ack_id,
    input logic [16*NUM_CORES-1:0] pend
);

    logic [16*NUM_CORES-1:0] ack_mask;
    logic [1:0]              mode;
    logic                    self_hit;
    int unsigned             hit_idx;

    assign mode = wr_data[25:24];

    always_comb begin
        ack_mask = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (ack_valid[c]) ack_mask[c*16 + int'(ack_id[c*4 +: 4])] = 1'b1;
        end
    end

    // self-mode write colliding with the writer's own acknowledge of the same ID
    assign self_hit = wr_valid && mode == 2'd2 && int'(wr_core) < NUM_CORES &&
                      ack_valid[wr_core] &&
                      ack_id[int'(wr_core)*4 +: 4] == wr_data[3:0];

    always_ff @(posedge clk) begin
        hit_idx <= int'(wr_core) * 16 + int'(wr_data[3:0]);
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pend == '0);

    assert_reserved_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && mode == 2'd3 && ack_valid == '0) |=> pend == $past(pend));

    assert_absent_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && mode == 2'd0 && wr_data[16 +: NUM_CORES] == '0 && ack_valid == '0)
        |=> pend == $past(pend));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        self_hit |=> pend[hit_idx]);

    assert_no_spurious_set_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (pend & ~$past(pend)) == '0);

    assert_clear_only_acked_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(pend) & ~pend & ~$past(ack_mask)) == '0);

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CORES(NUM_CORES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_core   (wr_core),
    .wr_data   (wr_data),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .pend      (pend)
);

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;

    localparam int N  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid;
    logic [CW-1:0] wr_core;
    logic [31:0]   wr_data;
    logic [N-1:0]  ack_valid;
    logic [4*N-1:0] ack_id;
    logic [16*N-1:0] pend;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    logic [16*N-1:0] mdl;

    always #10 clk = ~clk;   // 50 MHz

    sgi_dispatch #(.NUM_CORES(N)) i_sgi_dispatch (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_core(wr_core),
        .wr_data(wr_data), .ack_valid(ack_valid), .ack_id(ack_id), .pend(pend)
    );

    function automatic logic [31:0] word(int mode, int mask, int id);
        return (32'(mode) << 24) | (32'(mask & 8'hff) << 16) | 32'(id & 15);
    endfunction

    // behavioural reference: clears first, then sets
    task automatic model_edge();
        if (rst) begin
            mdl = '0;
        end else begin
            for (int c = 0; c < N; c++) begin
                bit hit;
                int m = int'(wr_data[25:24]);
                if (ack_valid[c]) mdl[c*16 + int'(ack_id[c*4 +: 4])] = 1'b0;
                hit = 0;
                if (m == 0) hit = wr_data[16 + c];
                else if (m == 1) hit = (c != int'(wr_core));
                else if (m == 2) hit = (c == int'(wr_core));
                if (wr_valid && hit) mdl[c*16 + int'(wr_data[3:0])] = 1'b1;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (pend !== mdl) begin
            errors++;
            $display("FAIL %s: pend=%h expected=%h", cur_req, pend, mdl);
        end
        wr_valid  = 1'b0;
        ack_valid = '0;
        ack_id    = '0;
    endtask

    task automatic check_bit(int c, int id, logic exp, string req);
        checks++;
        if (pend[c*16 + id] !== exp) begin
            errors++;
            $display("FAIL %s: core %0d id %0d got %b expected %b", req, c, id,
                     pend[c*16 + id], exp);
        end
    endtask

    task automatic send(int core, logic [31:0] w);
        wr_valid = 1'b1;
        wr_core  = CW'(core);
        wr_data  = w;
    endtask

    task automatic ack(int core, int id);
        ack_valid[core]       = 1'b1;
        ack_id[core*4 +: 4]   = 4'(id);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        mdl = '0;
        rst = 1'b1; wr_valid = 1'b0; wr_core = '0; wr_data = '0;
        ack_valid = '0; ack_id = '0;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        step(); step();
        rst = 1'b0;
        step();
        check_bit(0, 0, 1'b0, "R1");

        // R2: explicit list to cores 0 and 2, ID 5
        cur_req = "R2";
        send(1, word(0, 8'b0101, 5)); step();
        check_bit(0, 5, 1'b1, "R2"); check_bit(1, 5, 1'b0, "R2");
        check_bit(2, 5, 1'b1, "R2");

        // R7: junk in ignored bits, ID 9 to core 1
        cur_req = "R7";
        send(0, word(0, 8'b0010, 9) | 32'hFC00_FFF0); step();
        check_bit(1, 9, 1'b1, "R7"); check_bit(1, 15, 1'b0, "R7");

        // R3: all but writer core 1, ID 3, mask zero
        cur_req = "R3";
        send(1, word(1, 0, 3)); step();
        check_bit(1, 3, 1'b0, "R3"); check_bit(3, 3, 1'b1, "R3");

        // R4: writer only, mask full but ignored
        cur_req = "R4";
        send(3, word(2, 8'hFF, 12)); step();
        check_bit(3, 12, 1'b1, "R4"); check_bit(0, 12, 1'b0, "R4");

        // R6: mask names only absent cores
        cur_req = "R6";
        send(0, word(0, 8'hF0, 7)); step();
        for (int c = 0; c < N; c++) check_bit(c, 7, 1'b0, "R6");

        // R5: reserved mode dropped
        cur_req = "R5";
        send(2, word(3, 8'hFF, 1)); step();
        for (int c = 0; c < N; c++) check_bit(c, 1, 1'b0, "R5");

        // R8: core 0 acks ID 5, core 2 keeps its copy
        cur_req = "R8";
        ack(0, 5); step();
        check_bit(0, 5, 1'b0, "R8"); check_bit(2, 5, 1'b1, "R8");
        ack(3, 3); ack(1, 9); step();
        check_bit(3, 3, 1'b0, "R8"); check_bit(0, 3, 1'b1, "R8");

        // R9: set and ack on the same bit in the same cycle
        cur_req = "R9";
        send(2, word(2, 0, 0)); step();
        send(2, word(2, 0, 0)); ack(2, 0); step();
        check_bit(2, 0, 1'b1, "R9");
        send(0, word(0, 8'b0001, 6)); ack(0, 6); ack(2, 5); step();
        check_bit(0, 6, 1'b1, "R9"); check_bit(2, 5, 1'b0, "R9");

        // R10: idle cycles and acks of clear bits keep the rest
        cur_req = "R10";
        for (int i = 0; i < 6; i++) step();
        ack(1, 14); step();
        check_bit(3, 12, 1'b1, "R10"); check_bit(2, 0, 1'b1, "R10");

        // mixed traffic across modes and writers
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            send(i % N, word(i % 4, (i * 37) & 8'hFF, (i * 7) % 16));
            if (i % 3 == 0) ack(i % N, (i * 5) % 16);
            if (i % 5 == 0) ack((i + 1) % N, (i * 7) % 16);
            step();
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule